// File: doc/BRIEF.md
# Random-Access Pointer Override with Row/Column Linearization

This block lets an external agent jump the write pointer or the read pointer of a single-channel frame buffer FIFO to an arbitrary location. On a rising edge of the write-side clock, while the override valid input is high and the buffer runs as one channel, it captures a 24-bit address word, a read/write select bit, a mapping mode bit and the current row length. One clock later it presents a pointer address together with a one-cycle load strobe aimed at either the write pointer or the read pointer.

The mapping mode bit chooses how the captured word is read. In flat mode the word is taken as a plain linear address. In row/column mode the low half is the column and the high half is the row. The block then forms row times row length plus column. In both modes the result is cut to the memory address width.

When the buffer is split into two channels, the override pins serve other purposes, so every capture is suppressed. A sticky flag records any row/column capture whose column is not inside the programmed row. The address is still formed and loaded in that case.

Top module: `xaddr_override`

## Requirements
- R1: In flat mode (`map_2d_i` = 0), `ptr_addr_o` after a load equals the captured address word taken modulo 2^MEM_AW, that is, its low MEM_AW bits.
- R2: In row/column mode (`map_2d_i` = 1), bits [COORD_W-1:0] of the word are the column X and bits [2*COORD_W-1:COORD_W] are the row Y. After a load, `ptr_addr_o` equals (Y * row_len_i + X) modulo 2^MEM_AW, using the row length sampled with the address.
- R3: A capture with `rd_sel_i` = 0 pulses only `wptr_load_o`. A capture with `rd_sel_i` = 1 pulses only `rptr_load_o`. The two strobes are never high together.
- R4: Inputs sampled on clock edge k produce the strobe and the new `ptr_addr_o` after edge k+1, and not after edge k. The strobe lasts exactly one cycle per capture.
- R5: While `ovr_valid_i` is low, no strobe is produced and `ptr_addr_o` keeps its value, whatever the other inputs do.
- R6: While `dual_chan_i` is high, a valid override is ignored: no strobe, `ptr_addr_o` unchanged and `col_oor_o` unchanged.
- R7: `col_oor_o` becomes 1 with the load of a row/column capture whose column X is greater than or equal to the row length. It then stays 1 until reset. Flat-mode captures never set it.
- R8: While `rst_n` is low, both strobes, `ptr_addr_o` and `col_oor_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock; all capture happens on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovr_valid_i | input | 1 | Qualifies a capture of the override word |
| dual_chan_i | input | 1 | 1 when the buffer runs as two channels; disables the override |
| ovr_addr_i | input | 2*COORD_W | Override word: flat address, or row (high half) and column (low half) |
| rd_sel_i | input | 1 | 0 targets the write pointer, 1 targets the read pointer |
| map_2d_i | input | 1 | 0 flat mapping, 1 row/column mapping |
| row_len_i | input | COORD_W | Programmed row length used for row/column mapping |
| wptr_load_o | output | 1 | One-cycle load strobe for the write pointer |
| rptr_load_o | output | 1 | One-cycle load strobe for the read pointer |
| ptr_addr_o | output | MEM_AW | Address to load into the selected pointer |
| col_oor_o | output | 1 | Sticky flag: a row/column capture had a column outside the row |

## Verification
The hardest case to reach is the sticky flag's first rise, since it is visible only once. Any earlier out-of-row capture, or one in flat mode or dual-channel mode, would hide or wrongly set it. The stimulus therefore runs every flat-mode word with a zero row length first, where each column would count as out of row if the mode were ignored. It then runs dual-channel captures of out-of-row coordinates, and only after that sweeps row/column words with the row length descending from its maximum. This places the first true out-of-row column at a known vector. A small configuration (4-bit coordinates, 6-bit memory address) lets every word be tried under every row length, with the product truncation checked arithmetically.

// File: rtl/xao_pkg.sv
package xao_pkg;

  typedef enum logic {
    PTR_WR = 1'b0,
    PTR_RD = 1'b1
  } ptr_sel_e;

  typedef enum logic {
    MAP_FLAT = 1'b0,
    MAP_ROWCOL = 1'b1
  } map_mode_e;

endpackage

// File: rtl/xao_capture.sv
module xao_capture
  import xao_pkg::*;
#(
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ovr_valid_i,
  input  logic               dual_chan_i,
  input  logic [2*COORD_W-1:0] ovr_addr_i,
  input  logic               rd_sel_i,
  input  logic               map_2d_i,
  input  logic [COORD_W-1:0] row_len_i,
  output logic               cap_vld_o,
  output ptr_sel_e           cap_sel_o,
  output map_mode_e          cap_mode_o,
  output logic [COORD_W-1:0] cap_row_o,
  output logic [COORD_W-1:0] cap_col_o,
  output logic [COORD_W-1:0] cap_len_o
);

  logic               take;
  logic               vld_n;
  ptr_sel_e           sel_n;
  map_mode_e          mode_n;
  logic [COORD_W-1:0] row_n, col_n, len_n;

  assign take = ovr_valid_i & ~dual_chan_i;

  always_comb begin
    vld_n  = take;
    sel_n  = cap_sel_o;
    mode_n = cap_mode_o;
    row_n  = cap_row_o;
    col_n  = cap_col_o;
    len_n  = cap_len_o;
    if (take) begin
      sel_n  = ptr_sel_e'(rd_sel_i);
      mode_n = map_mode_e'(map_2d_i);
      row_n  = ovr_addr_i[2*COORD_W-1:COORD_W];
      col_n  = ovr_addr_i[COORD_W-1:0];
      len_n  = row_len_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_vld_o  <= 1'b0;
      cap_sel_o  <= PTR_WR;
      cap_mode_o <= MAP_FLAT;
      cap_row_o  <= '0;
      cap_col_o  <= '0;
      cap_len_o  <= '0;
    end else begin
      cap_vld_o  <= vld_n;
      cap_sel_o  <= sel_n;
      cap_mode_o <= mode_n;
      cap_row_o  <= row_n;
      cap_col_o  <= col_n;
      cap_len_o  <= len_n;
    end
  end

endmodule

// File: rtl/xao_linearize.sv
module xao_linearize
  import xao_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int MEM_AW  = 22
) (
  input  map_mode_e          mode_i,
  input  logic [COORD_W-1:0] row_i,
  input  logic [COORD_W-1:0] col_i,
  input  logic [COORD_W-1:0] len_i,
  output logic [MEM_AW-1:0]  addr_o,
  output logic               oor_o
);

  localparam int FLAT_W = 2 * COORD_W;
  localparam int SUM_W  = 2 * COORD_W + 1;

  logic [FLAT_W-1:0] flat_word;
  logic [FLAT_W-1:0] product;
  logic [SUM_W-1:0]  sum;
  logic [MEM_AW-1:0] flat_fit;
  logic [MEM_AW-1:0] sum_fit;

  assign flat_word = {row_i, col_i};
  assign product   = row_i * len_i;
  assign sum       = {1'b0, product} + {{(SUM_W-COORD_W){1'b0}}, col_i};

  generate
    if (MEM_AW <= FLAT_W) begin : g_flat_cut
      assign flat_fit = flat_word[MEM_AW-1:0];
    end else begin : g_flat_ext
      assign flat_fit = {{(MEM_AW-FLAT_W){1'b0}}, flat_word};
    end

    if (MEM_AW <= SUM_W) begin : g_sum_cut
      assign sum_fit = sum[MEM_AW-1:0];
    end else begin : g_sum_ext
      assign sum_fit = {{(MEM_AW-SUM_W){1'b0}}, sum};
    end
  endgenerate

  assign addr_o = (mode_i == MAP_ROWCOL) ? sum_fit : flat_fit;
  assign oor_o  = (mode_i == MAP_ROWCOL) && (col_i >= len_i);

endmodule

// File: rtl/xao_issue.sv
module xao_issue
  import xao_pkg::*;
#(
  parameter int MEM_AW = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_vld_i,
  input  ptr_sel_e          cap_sel_i,
  input  logic [MEM_AW-1:0] lin_addr_i,
  input  logic              lin_oor_i,
  output logic              wptr_load_o,
  output logic              rptr_load_o,
  output logic [MEM_AW-1:0] ptr_addr_o,
  output logic              col_oor_o
);

  logic              wld_n, rld_n, oor_n;
  logic [MEM_AW-1:0] addr_n;

  always_comb begin
    wld_n  = cap_vld_i && (cap_sel_i == PTR_WR);
    rld_n  = cap_vld_i && (cap_sel_i == PTR_RD);
    addr_n = ptr_addr_o;
    oor_n  = col_oor_o;
    if (cap_vld_i) begin
      addr_n = lin_addr_i;
      oor_n  = col_oor_o | lin_oor_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_load_o <= 1'b0;
      rptr_load_o <= 1'b0;
      ptr_addr_o  <= '0;
      col_oor_o   <= 1'b0;
    end else begin
      wptr_load_o <= wld_n;
      rptr_load_o <= rld_n;
      ptr_addr_o  <= addr_n;
      col_oor_o   <= oor_n;
    end
  end

endmodule

// File: rtl/xaddr_override.sv
module xaddr_override
  import xao_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int MEM_AW  = 22
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ovr_valid_i,
  input  logic                 dual_chan_i,
  input  logic [2*COORD_W-1:0] ovr_addr_i,
  input  logic                 rd_sel_i,
  input  logic                 map_2d_i,
  input  logic [COORD_W-1:0]   row_len_i,
  output logic                 wptr_load_o,
  output logic                 rptr_load_o,
  output logic [MEM_AW-1:0]    ptr_addr_o,
  output logic                 col_oor_o
);

  logic               cap_vld;
  ptr_sel_e           cap_sel;
  map_mode_e          cap_mode;
  logic [COORD_W-1:0] cap_row, cap_col, cap_len;
  logic [MEM_AW-1:0]  lin_addr;
  logic               lin_oor;

  xao_capture #(.COORD_W(COORD_W)) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .ovr_valid_i(ovr_valid_i),
    .dual_chan_i(dual_chan_i),
    .ovr_addr_i (ovr_addr_i),
    .rd_sel_i   (rd_sel_i),
    .map_2d_i   (map_2d_i),
    .row_len_i  (row_len_i),
    .cap_vld_o  (cap_vld),
    .cap_sel_o  (cap_sel),
    .cap_mode_o (cap_mode),
    .cap_row_o  (cap_row),
    .cap_col_o  (cap_col),
    .cap_len_o  (cap_len)
  );

  xao_linearize #(.COORD_W(COORD_W), .MEM_AW(MEM_AW)) u_linearize (
    .mode_i(cap_mode),
    .row_i (cap_row),
    .col_i (cap_col),
    .len_i (cap_len),
    .addr_o(lin_addr),
    .oor_o (lin_oor)
  );

  xao_issue #(.MEM_AW(MEM_AW)) u_issue (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_vld_i  (cap_vld),
    .cap_sel_i  (cap_sel),
    .lin_addr_i (lin_addr),
    .lin_oor_i  (lin_oor),
    .wptr_load_o(wptr_load_o),
    .rptr_load_o(rptr_load_o),
    .ptr_addr_o (ptr_addr_o),
    .col_oor_o  (col_oor_o)
  );

endmodule

// File: rtl/xaddr_override_chk.sv
module xaddr_override_chk #(
  parameter int MEM_AW = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ovr_valid_i,
  input logic              dual_chan_i,
  input logic              rd_sel_i,
  input logic              wptr_load_o,
  input logic              rptr_load_o,
  input logic [MEM_AW-1:0] ptr_addr_o,
  input logic              col_oor_o
);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wptr_load_o && rptr_load_o)); // R3

  AST_WR_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_valid_i && !dual_chan_i && !rd_sel_i) |=> ##1 wptr_load_o); // R3

  AST_RD_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_valid_i && !dual_chan_i && rd_sel_i) |=> ##1 rptr_load_o); // R3

  AST_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovr_valid_i || dual_chan_i) |=> ##1 !(wptr_load_o || rptr_load_o)); // R4

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wptr_load_o || rptr_load_o) |-> $stable(ptr_addr_o)); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    col_oor_o |=> col_oor_o); // R7

  AST_FLAG_WITH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col_oor_o) |-> (wptr_load_o || rptr_load_o)); // R7

endmodule

bind xaddr_override xaddr_override_chk #(.MEM_AW(MEM_AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ovr_valid_i(ovr_valid_i),
  .dual_chan_i(dual_chan_i),
  .rd_sel_i   (rd_sel_i),
  .wptr_load_o(wptr_load_o),
  .rptr_load_o(rptr_load_o),
  .ptr_addr_o (ptr_addr_o),
  .col_oor_o  (col_oor_o)
);

// File: tb/xaddr_override_bench.sv
`timescale 1ns/1ps
module xaddr_override_bench;

  localparam int CW = 4;
  localparam int AW = 6;
  localparam int WW = 2 * CW;

  logic          clk;
  logic          rst_n;
  logic          ovr_valid_i, dual_chan_i, rd_sel_i, map_2d_i;
  logic [WW-1:0] ovr_addr_i;
  logic [CW-1:0] row_len_i;
  logic          wptr_load_o, rptr_load_o, col_oor_o;
  logic [AW-1:0] ptr_addr_o;

  int n_tests;
  int n_fail;
  bit done;

  int          exp_addr;
  bit          exp_flag;

  xaddr_override #(.COORD_W(CW), .MEM_AW(AW)) u_xaddr_override (
    .clk(clk), .rst_n(rst_n), .ovr_valid_i(ovr_valid_i), .dual_chan_i(dual_chan_i),
    .ovr_addr_i(ovr_addr_i), .rd_sel_i(rd_sel_i), .map_2d_i(map_2d_i),
    .row_len_i(row_len_i), .wptr_load_o(wptr_load_o), .rptr_load_o(rptr_load_o),
    .ptr_addr_o(ptr_addr_o), .col_oor_o(col_oor_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Apply one override vector and check latency, routing, address and flag.
  task automatic apply(input bit vld, input bit dual, input int word, input bit rd,
                       input bit m2d, input int len);
    int  x, y;
    bit  takes;
    string areq;
    @(negedge clk);
    ovr_valid_i = vld; dual_chan_i = dual; ovr_addr_i = WW'(word);
    rd_sel_i = rd; map_2d_i = m2d; row_len_i = CW'(len);
    @(negedge clk);
    ovr_valid_i = 1'b0;
    // R4: nothing visible after the capturing edge alone
    check("R4", {wptr_load_o, rptr_load_o}, 0);
    takes = vld && !dual;
    x = word % (1 << CW);
    y = word / (1 << CW);
    if (takes) begin
      if (m2d) begin
        exp_addr = (y * len + x) % (1 << AW);
        if (x >= len) exp_flag = 1'b1;
        areq = "R2";
      end else begin
        exp_addr = word % (1 << AW);
        areq = "R1";
      end
    end else begin
      areq = dual ? "R6" : "R5";
    end
    @(negedge clk);
    // R3: strobe routing by select bit
    check(takes ? "R3" : areq, {wptr_load_o, rptr_load_o},
          takes ? (rd ? 1 : 2) : 0);
    check(areq, int'(ptr_addr_o), exp_addr);
    check(dual ? "R6" : "R7", int'(col_oor_o), int'(exp_flag));
    @(negedge clk);
    // R4: strobe lasts one cycle
    check("R4", {wptr_load_o, rptr_load_o}, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ovr_valid_i = 1'b0;
    @(negedge clk);
    check("R8", {wptr_load_o, rptr_load_o, col_oor_o}, 0);
    check("R8", int'(ptr_addr_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    exp_addr = 0;
    exp_flag = 1'b0;
  endtask

  initial begin
    n_tests = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; ovr_valid_i = 1'b0; dual_chan_i = 1'b0; rd_sel_i = 1'b0;
    map_2d_i = 1'b0; ovr_addr_i = '0; row_len_i = '0;
    exp_addr = 0; exp_flag = 1'b0;
    repeat (3) @(negedge clk);
    do_reset();

    // R5: idle, no valid
    apply(1'b0, 1'b0, 8'h3f, 1'b1, 1'b1, 0);

    // R1 and R7: every flat word, zero row length must not raise the flag
    for (int w = 0; w < (1 << WW); w++)
      apply(1'b1, 1'b0, w, w[0] ^ w[1], 1'b0, 0);

    // R6: dual-channel captures of out-of-row coordinates are ignored
    for (int w = 0; w < 8; w++)
      apply(1'b1, 1'b1, (w << CW) | 15, w[0], 1'b1, 3);

    // R5: inputs move while valid is low
    apply(1'b0, 1'b0, 8'h5a, 1'b0, 1'b1, 2);

    // R2 and R7: row/column sweep, row length descending
    for (int len = (1 << CW) - 1; len >= 0; len--)
      for (int w = 0; w < (1 << WW); w++)
        apply(1'b1, 1'b0, w, w[2], 1'b1, len);

    // R8: reset clears the sticky flag and the address
    do_reset();
    apply(1'b1, 1'b0, 8'h21, 1'b1, 1'b1, 4);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule